// File: doc/BRIEF.md
# Double-Bank Task Handoff Buffer

This block passes whole arrays from one producer task to one consumer task through two storage banks, each as deep as the array. While the producer fills one bank by random address, the consumer reads the other bank by random address. Neither side has to follow a sequential order. Each side ends its round with a single-cycle done pulse. That pulse hands the bank over and moves the side to the other bank, so the two banks trade roles on every round.

A per-bank full flag tracks the handoff. A producer done pulse sets the flag of the bank the producer has just filled. A consumer done pulse clears the flag of the bank the consumer has just drained. The producer is held off while both banks are full. The consumer is held off while neither bank is full. Read data comes back one clock after the read address is presented.

Top module: `pingpong_buf`

## Requirements
- R1: After reset, both full flags are 0, both sides point at bank 0, wr_ready is 1 and rd_valid is 0.
- R2: While wr_ready is 1, a cycle with wr_en high stores wr_data at wr_addr in the bank given by wr_bank. Addresses may arrive in any order.
- R3: A wr_done pulse while wr_ready is 1 sets the full flag of the current producer bank (bit index equals the bank number in bank_full) and moves wr_bank to the other bank.
- R4: wr_ready is 0 exactly when both banks are full. While it is 0, wr_en and wr_done change neither the bank contents, bank_full nor wr_bank.
- R5: rd_valid is 1 exactly when the consumer's bank is full. rd_data shows the word at rd_addr of bank rd_bank one clock after rd_addr is applied.
- R6: A rd_done pulse while rd_valid is 1 clears the full flag of the consumer's bank and moves rd_bank to the other bank. A rd_done pulse while rd_valid is 0 has no effect.
- R7: The producer and the consumer never own the same bank while wr_ready and rd_valid are both 1.
- R8: Both sides visit the banks in the order 0, 1, 0, 1, so the consumer receives arrays in the order they were produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Producer write strobe |
| wr_addr | input | ADDR_W | Producer word address |
| wr_data | input | DATA_W | Producer write data |
| wr_done | input | 1 | Producer end-of-round pulse |
| wr_ready | output | 1 | Producer may write (a free bank exists) |
| wr_bank | output | 1 | Bank currently owned by the producer |
| rd_addr | input | ADDR_W | Consumer word address |
| rd_data | output | DATA_W | Read data, one cycle after rd_addr |
| rd_done | input | 1 | Consumer end-of-round pulse |
| rd_valid | output | 1 | Consumer bank holds a finished array |
| rd_bank | output | 1 | Bank currently owned by the consumer |
| bank_full | output | 2 | Full flag per bank, bit n for bank n |

## Verification
The hardest state to reach is the one where both banks are full. In that state the producer is stalled, and its strobes must be shown to be ignored. The bench reaches it by completing two producer rounds before the consumer drains anything. It then fires a write and a done pulse at the stalled producer and reads back the whole bank the write would have hit. The arrays are written in reversed, scrambled and ascending address orders and read back in different orders. Every word is predicted from its round number and address.

// File: rtl/pp_pkg.sv
package pp_pkg;
   localparam int NUM_BANKS = 2;

   function automatic logic other_bank(input logic b);
      return ~b;
   endfunction
endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      rdata <= store[raddr];
   end
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
   import pp_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_done,
   input  logic                 rd_done,
   output logic                 wr_ready,
   output logic                 rd_valid,
   output logic                 wr_bank,
   output logic                 rd_bank,
   output logic [NUM_BANKS-1:0] full
);
   logic wr_fire, rd_fire;

   assign wr_ready = ~full[wr_bank];
   assign rd_valid = full[rd_bank];
   assign wr_fire  = wr_done & wr_ready;
   assign rd_fire  = rd_done & rd_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= 1'b0;
         rd_bank <= 1'b0;
         full    <= '0;
      end else begin
         if (wr_fire) wr_bank <= other_bank(wr_bank);
         if (rd_fire) rd_bank <= other_bank(rd_bank);
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (wr_fire && (wr_bank == b[0])) full[b] <= 1'b1;
            else if (rd_fire && (rd_bank == b[0])) full[b] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pingpong_buf.sv
module pingpong_buf
   import pp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_done,
   output logic              wr_ready,
   output logic              wr_bank,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rd_done,
   output logic              rd_valid,
   output logic              rd_bank,
   output logic [1:0]        bank_full
);
   initial begin
      if (DEPTH < 2)  $fatal(1, "pingpong_buf: DEPTH must be at least 2");
      if (DATA_W < 1) $fatal(1, "pingpong_buf: DATA_W must be positive");
   end

   logic [DATA_W-1:0] bank_q [NUM_BANKS];
   logic              sel_q;

   pp_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_done  (wr_done),
      .rd_done  (rd_done),
      .wr_ready (wr_ready),
      .rd_valid (rd_valid),
      .wr_bank  (wr_bank),
      .rd_bank  (rd_bank),
      .full     (bank_full)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      pp_bank_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
         .clk   (clk),
         .we    (wr_en && wr_ready && (wr_bank == g[0])),
         .waddr (wr_addr),
         .wdata (wr_data),
         .raddr (rd_addr),
         .rdata (bank_q[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= rd_bank;
   end

   assign rd_data = bank_q[sel_q];
endmodule

// File: rtl/pingpong_buf_chk.sv
module pingpong_buf_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_done,
   input logic       wr_ready,
   input logic       wr_bank,
   input logic       rd_done,
   input logic       rd_valid,
   input logic       rd_bank,
   input logic [1:0] bank_full
);
   // R7
   bank_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready && rd_valid) |-> (wr_bank != rd_bank));

   // R3
   prod_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && wr_ready) |=> (wr_bank != $past(wr_bank)) && bank_full[$past(wr_bank)]);

   // R4
   prod_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |=> $stable(wr_bank));

   // R6
   cons_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && rd_valid) |=> (rd_bank != $past(rd_bank)) && !bank_full[$past(rd_bank)]);

   // R6
   cons_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(rd_bank));

   // R5
   starve_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> wr_ready);
endmodule

bind pingpong_buf pingpong_buf_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_done   (wr_done),
   .wr_ready  (wr_ready),
   .wr_bank   (wr_bank),
   .rd_done   (rd_done),
   .rd_valid  (rd_valid),
   .rd_bank   (rd_bank),
   .bank_full (bank_full)
);

// File: tb/test_pingpong_buf.sv
`timescale 1ns/1ps
module test_pingpong_buf;
   localparam int DW = 8;
   localparam int DP = 8;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0, wr_done = 1'b0, rd_done = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready, wr_bank, rd_valid, rd_bank;
   logic [DW-1:0] rd_data;
   logic [1:0]    bank_full;
   int checks = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pingpong_buf #(.DATA_W(DW), .DEPTH(DP)) i_pingpong_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_done(wr_done), .wr_ready(wr_ready), .wr_bank(wr_bank), .rd_addr(rd_addr),
      .rd_data(rd_data), .rd_done(rd_done), .rd_valid(rd_valid), .rd_bank(rd_bank),
      .bank_full(bank_full)
   );

   function automatic logic [DW-1:0] word_of(int k, int a);
      return DW'((k * 37 + a * 11 + 5) & 8'hFF);
   endfunction

   // order 0: reversed, 1: scrambled, 2: ascending
   function automatic logic [AW-1:0] addr_of(int ord, int i);
      if (ord == 0) return AW'(DP - 1 - i);
      if (ord == 1) return AW'((i * 5 + 3) % DP);
      return AW'(i);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_round(int k, int ord);
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = addr_of(ord, i); wr_data = word_of(k, int'(addr_of(ord, i)));
      end
      @(negedge clk);
      wr_en = 1'b0; wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
   endtask

   task automatic read_round(int k, int ord, string req);
      for (int i = 0; i < DP; i++) begin
         @(negedge clk);
         rd_addr = addr_of(ord, i);
         @(negedge clk);
         chk(rd_data == word_of(k, int'(addr_of(ord, i))), req, int'(rd_data),
             int'(word_of(k, int'(addr_of(ord, i)))));
      end
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(bank_full == 2'b00, "R1", int'(bank_full), 0);
      chk(wr_bank == 1'b0 && rd_bank == 1'b0, "R1", int'({wr_bank, rd_bank}), 0);
      chk(wr_ready && !rd_valid, "R1", int'({wr_ready, rd_valid}), 2);
      // R6 done with nothing to consume is ignored
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      chk(rd_bank == 1'b0 && bank_full == 2'b00, "R6", int'({rd_bank, bank_full}), 0);
      // R2 R3 first round, reversed order
      write_round(0, 0);
      chk(bank_full == 2'b01 && wr_bank == 1'b1, "R3", int'({wr_bank, bank_full}), 5);
      chk(rd_valid && wr_ready, "R5", int'({rd_valid, wr_ready}), 3);
      // second round scrambled fills both banks
      write_round(1, 1);
      chk(bank_full == 2'b11 && !wr_ready, "R4", int'({wr_ready, bank_full}), 3);
      chk(wr_bank == 1'b0, "R8", int'(wr_bank), 0);
      // R4 stalled producer strobes are ignored
      wr_en = 1'b1; wr_addr = 3'd3; wr_data = ~word_of(0, 3); wr_done = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_done = 1'b0;
      chk(bank_full == 2'b11 && wr_bank == 1'b0, "R4", int'({wr_bank, bank_full}), 3);
      read_round(0, 1, "R4");
      chk(rd_bank == 1'b1 && bank_full == 2'b10 && wr_ready, "R6",
          int'({wr_ready, rd_bank, bank_full}), 14);
      read_round(1, 0, "R5");
      chk(rd_bank == 1'b0 && bank_full == 2'b00 && !rd_valid, "R8",
          int'({rd_valid, rd_bank, bank_full}), 0);
      for (int k = 2; k < 6; k++) begin
         write_round(k, k % 3);
         chk(wr_bank == 1'((k + 1) % 2), "R8", int'(wr_bank), (k + 1) % 2);
         chk(rd_valid, "R5", int'(rd_valid), 1);
         read_round(k, (k + 1) % 3, "R2");
         chk(rd_bank == 1'((k + 1) % 2), "R8", int'(rd_bank), (k + 1) % 2);
      end
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule